// File: doc/BRIEF.md
# LDPC Variable Node Update Unit

This unit performs the bit-side step of min-sum or sum-product message passing for one variable node of fixed degree. It takes a signed channel log-likelihood and one signed check-to-bit message for each edge. It forms a single running total from the channel value and all of those messages. From that one total it derives every outgoing bit-to-check message: for each edge, the unit removes that edge's own input so that the message carries only information from the other edges. The sign of the same total also gives the tentative hard decision for the bit.

A decoder instantiates one copy per variable node, or reuses one copy serially across nodes. On each accepted strobe it presents a fresh set of messages one clock later. The strobe may be flagged as the first iteration. In that case no check messages exist yet, so the incoming messages are ignored and every output carries the channel value.

Top module: `ldpc_bitnode`

## Requirements
- R1: While reset is asserted and after it is released, `outValid`, `hardBit` and every lane of `v2cMsg` read zero until the first accepted strobe.
- R2: When a strobe is accepted and `firstIter` is low, lane i of `v2cMsg` (bits [i*MW +: MW]) equals `chanLlr` plus the sum of all `c2vMsg` lanes except lane i, whenever that value lies within the message range. All values are two's complement.
- R3: An outgoing message whose exact value exceeds +15 (for MW=5) is output as +15.
- R4: An outgoing message whose exact value is below -16 (for MW=5) is output as -16.
- R5: `hardBit` is 1 when the channel value plus all incoming messages is negative, and 0 when that sum is zero or positive.
- R6: On a strobe with `firstIter` high, the `c2vMsg` lanes have no effect. Every lane of `v2cMsg` equals `chanLlr`, and `hardBit` equals the sign of `chanLlr`.
- R7: `outValid` is high in exactly the cycle after each cycle in which `inValid` is high, and low otherwise.
- R8: In a cycle with `inValid` low, changes on `chanLlr`, `c2vMsg` and `firstIter` leave `v2cMsg` and `hardBit` unchanged.
- R9: The total is held at full width before any message is formed. Intermediate sums never wrap, so saturation applies only to the final per-edge value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input strobe; inputs are accepted in this cycle |
| firstIter | input | 1 | Marks the strobe as the first decoding iteration |
| chanLlr | input | MW | Signed channel log-likelihood |
| c2vMsg | input | DEG*MW | Signed check-to-bit messages, edge i at [i*MW +: MW] |
| outValid | output | 1 | Outputs were refreshed in the previous cycle |
| v2cMsg | output | DEG*MW | Saturated bit-to-check messages, edge i at [i*MW +: MW] |
| hardBit | output | 1 | Hard decision, 1 when the total is negative |

## Verification
Any corruption of the shared total shows up at the ports one clock after the strobe. It appears as a coordinated shift of every lane together with a possible flip of `hardBit`. A lane that subtracts the wrong edge, or none, shows up in that lane alone. Narrowing the total makes the sums wrap, which shows as a sign-flipped lane on strongly saturated vectors. A fault in the strobe path shows as `outValid` out of step, or as outputs moving in idle cycles, in the very next cycle.

// File: rtl/ldpc_bitnode_pkg.sv
package ldpc_bitnode_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic capture;  // load the output registers this cycle
    logic maskIn;   // treat incoming check messages as zero
  } bnStrobe_t;

endpackage

// File: rtl/ldpc_bitnode_ctrl.sv
module ldpc_bitnode_ctrl
  import ldpc_bitnode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       firstIter,
  output bnStrobe_t  strobe,
  output logic       outValid
);

  always_comb begin
    strobe.capture = inValid;
    strobe.maskIn  = inValid & firstIter;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

endmodule

// File: rtl/ldpc_bitnode_dp.sv
module ldpc_bitnode_dp
  import ldpc_bitnode_pkg::*;
#(
  parameter int DEG = 5,
  parameter int MW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bnStrobe_t         strobe,
  input  logic [MW-1:0]     chanLlr,
  input  logic [DEG*MW-1:0] c2vMsg,
  output logic [DEG*MW-1:0] v2cMsg,
  output logic              hardBit
);

  // Full width: room for DEG+1 addends plus one bit for the subtraction.
  localparam int TW = MW + $clog2(DEG + 1) + 1;
  localparam logic signed [TW-1:0] SAT_HI = TW'((2 ** (MW - 1)) - 1);
  localparam logic signed [TW-1:0] SAT_LO = -SAT_HI - TW'(1);

  function automatic logic signed [TW-1:0] widen(input logic [MW-1:0] v);
    return {{(TW - MW){v[MW-1]}}, v};
  endfunction

  function automatic logic [MW-1:0] clampMsg(input logic signed [TW-1:0] v);
    logic signed [TW-1:0] r;
    if (v > SAT_HI)      r = SAT_HI;
    else if (v < SAT_LO) r = SAT_LO;
    else                 r = v;
    return r[MW-1:0];
  endfunction

  logic signed [TW-1:0] effIn [DEG];
  logic signed [TW-1:0] total;
  logic [MW-1:0]        extNext [DEG];

  // Zero the incoming edges on a first-iteration strobe.
  genvar g;
  generate
    for (g = 0; g < DEG; g++) begin : g_in
      always_comb begin
        if (strobe.maskIn) effIn[g] = '0;
        else               effIn[g] = widen(c2vMsg[g*MW +: MW]);
      end
    end
  endgenerate

  // One shared total over the channel value and all edges.
  always_comb begin
    total = widen(chanLlr);
    for (int i = 0; i < DEG; i++) begin
      total = total + effIn[i];
    end
  end

  // Each edge removes its own contribution, then saturates.
  generate
    for (g = 0; g < DEG; g++) begin : g_ext
      always_comb begin
        extNext[g] = clampMsg(total - effIn[g]);
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v2cMsg[g*MW +: MW] <= '0;
        end else if (strobe.capture) begin
          v2cMsg[g*MW +: MW] <= extNext[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hardBit <= 1'b0;
    end else if (strobe.capture) begin
      hardBit <= total[TW-1];
    end
  end

endmodule

// File: rtl/ldpc_bitnode.sv
module ldpc_bitnode
  import ldpc_bitnode_pkg::*;
#(
  parameter int DEG = 5,
  parameter int MW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              firstIter,
  input  logic [MW-1:0]     chanLlr,
  input  logic [DEG*MW-1:0] c2vMsg,
  output logic              outValid,
  output logic [DEG*MW-1:0] v2cMsg,
  output logic              hardBit
);

  bnStrobe_t strobe;

  ldpc_bitnode_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .firstIter(firstIter),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ldpc_bitnode_dp #(.DEG(DEG), .MW(MW)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .chanLlr(chanLlr),
    .c2vMsg (c2vMsg),
    .v2cMsg (v2cMsg),
    .hardBit(hardBit)
  );

endmodule

// File: rtl/ldpc_bitnode_chk.sv
module ldpc_bitnode_chk #(
  parameter int DEG = 5,
  parameter int MW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              firstIter,
  input logic [MW-1:0]     chanLlr,
  input logic [DEG*MW-1:0] c2vMsg,
  input logic              outValid,
  input logic [DEG*MW-1:0] v2cMsg,
  input logic              hardBit
);

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(v2cMsg) && $stable(hardBit)));

  assert_first_hard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && firstIter) |=> (hardBit == $past(chanLlr[MW-1])));

  genvar g;
  generate
    for (g = 0; g < DEG; g++) begin : g_lane
      assert_first_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && firstIter) |=> (v2cMsg[g*MW +: MW] == $past(chanLlr)));
    end
  endgenerate

endmodule

bind ldpc_bitnode ldpc_bitnode_chk #(.DEG(DEG), .MW(MW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .firstIter(firstIter),
  .chanLlr  (chanLlr),
  .c2vMsg   (c2vMsg),
  .outValid (outValid),
  .v2cMsg   (v2cMsg),
  .hardBit  (hardBit)
);

// File: tb/ldpc_bitnode_tb_top.sv
module ldpc_bitnode_tb_top;
  localparam int DEG = 5;
  localparam int MW  = 5;
  localparam int HI  = (2 ** (MW - 1)) - 1;
  localparam int LO  = -(2 ** (MW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic firstIter = 1'b0;
  logic [MW-1:0] chanLlr = '0;
  logic [DEG*MW-1:0] c2vMsg = '0;
  logic outValid;
  logic [DEG*MW-1:0] v2cMsg;
  logic hardBit;

  always #4 clk = ~clk;  // 8 ns period

  ldpc_bitnode #(.DEG(DEG), .MW(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .firstIter(firstIter),
    .chanLlr(chanLlr), .c2vMsg(c2vMsg), .outValid(outValid),
    .v2cMsg(v2cMsg), .hardBit(hardBit)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit armed = 0;
  string curTag = "R1";

  // Behavioural reference model.
  int expMsg [DEG];
  bit expHard = 0;
  bit expValid = 0;

  function automatic int lane(input int i);
    return $signed(v2cMsg[i*MW +: MW]);
  endfunction

  function automatic int clampI(input int v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  always @(posedge clk) begin
    armed <= 1'b1;
    if (!rst_n) begin
      for (int i = 0; i < DEG; i++) expMsg[i] = 0;
      expHard  = 0;
      expValid = 0;
    end else begin
      expValid = inValid;
      if (inValid) begin
        int sum;
        int m [DEG];
        sum = $signed(chanLlr);
        for (int i = 0; i < DEG; i++) begin
          m[i] = firstIter ? 0 : int'($signed(c2vMsg[i*MW +: MW]));
          sum += m[i];
        end
        for (int i = 0; i < DEG; i++) expMsg[i] = clampI(sum - m[i]);
        expHard = (sum < 0);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (armed && !done) begin
      check({curTag, " model valid"}, int'(outValid), int'(expValid));
      check({curTag, " model hard"}, int'(hardBit), int'(expHard));
      for (int i = 0; i < DEG; i++) check({curTag, " model lane"}, lane(i), expMsg[i]);
    end
  end

  task automatic apply(input int ch, input int m0, input int m1, input int m2,
                       input int m3, input int m4, input bit first);
    int mm [DEG];
    mm = '{m0, m1, m2, m3, m4};
    chanLlr = MW'(ch);
    for (int i = 0; i < DEG; i++) c2vMsg[i*MW +: MW] = MW'(mm[i]);
    firstIter = first;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectAll(input string tag, input int e0, input int e1, input int e2,
                           input int e3, input int e4, input int eh);
    int ee [DEG];
    ee = '{e0, e1, e2, e3, e4};
    for (int i = 0; i < DEG; i++) check(tag, lane(i), ee[i]);
    check(tag, int'(hardBit), eh);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state.
    check("R1 valid", int'(outValid), 0);
    expectAll("R1 reset", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expectAll("R1 after release", 0, 0, 0, 0, 0, 0);

    // R2 / R7: plain extrinsic sums, total 5.
    curTag = "R2";
    apply(3, 1, -2, 4, 0, -1, 0);
    check("R7 valid high", int'(outValid), 1);
    expectAll("R2 extrinsic", 4, 7, 1, 5, 6, 0);
    @(negedge clk);
    check("R7 valid one cycle", int'(outValid), 0);

    // R8: idle input changes ignored.
    curTag = "R8";
    chanLlr = MW'(-9);
    c2vMsg = {DEG{5'b10101}};
    firstIter = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expectAll("R8 hold", 4, 7, 1, 5, 6, 0);

    curTag = "R3";
    apply(10, 8, 8, 8, 8, 8, 0);
    expectAll("R3 positive clamp", 15, 15, 15, 15, 15, 0);

    curTag = "R4";
    apply(-12, -9, -9, -9, -9, -9, 0);
    expectAll("R4 negative clamp", -16, -16, -16, -16, -16, 1);

    curTag = "R5";
    apply(2, -2, 0, 0, 0, 0, 0);
    expectAll("R5 zero total", 2, 0, 0, 0, 0, 0);
    apply(-1, 0, 0, 0, 0, 0, 0);
    expectAll("R5 minus one", -1, -1, -1, -1, -1, 1);

    curTag = "R6";
    apply(-7, 15, 15, 15, 15, 15, 1);
    expectAll("R6 first iteration", -7, -7, -7, -7, -7, 1);
    apply(6, -16, -16, 3, -4, 9, 1);
    expectAll("R6 first positive", 6, 6, 6, 6, 6, 0);

    curTag = "R9";
    apply(-16, 15, 15, 15, 15, -16, 0);
    expectAll("R9 full width", 13, 13, 13, 13, 15, 0);

    // R2/R3/R4/R7: random mix, back-to-back and gapped strobes.
    curTag = "R2 random";
    for (int n = 0; n < 400; n++) begin
      chanLlr = MW'($urandom_range(0, 31));
      c2vMsg = DEG*MW'($urandom);
      firstIter = ($urandom_range(0, 7) == 0);
      inValid = ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    inValid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule